// File: doc/BRIEF.md
# Peripheral-to-Pin Signal Routing Matrix

This block is a configurable crossbar between a bank of general-purpose pins and the on-chip peripherals. Every peripheral input signal owns an input select word that picks one pin, or a constant level, as its source. The word can invert that value, or it can hand the peripheral its dedicated direct-path signal instead. Every pin owns an output select word that picks one of the peripheral output signals, or the pin's own bit of the simple output and output-enable registers, as its source. The output value can be inverted. The output enable can be sourced and inverted on its own.

The routing is purely combinational from the stored select words. A select word is written over a simple register bus and takes effect on the cycle after the write. Select words are read back combinationally at their bus addresses. Input select word s sits at word address s. Output select word p sits at word address OUT_BASE + p, which is 128 + p by default. Pad electrical behaviour is not part of the block.

Top module: `ioxb_matrix`

## Requirements
- R1: After reset, every input select word reads 0x30 and every output select word reads 0x100. Every peripheral input then equals its direct-path signal, and every pin output and output enable equal that pin's gpio_out and gpio_en bits.
- R2: With input word bit 7 set and bit 6 clear, a pin code of 0 to NUM_PINS-1 in bits 5:0 drives the peripheral input from pin_in at that index.
- R3: With bit 7 set and bit 6 clear, pin code 0x20 gives a constant 1. Code 0x30, and every code from NUM_PINS to 63 other than 0x20, gives a constant 0.
- R4: Input word bit 6 inverts the value chosen by the pin code when bit 7 is set.
- R5: With input word bit 7 clear, the peripheral input equals direct_in for that signal, whatever bits 6:0 hold.
- R6: An output word code below NUM_PSIG in bits 8:0 drives the pin from periph_out at that index. With bit 10 clear, it also takes the output enable from periph_oe at that index.
- R7: An output word code of NUM_PSIG or above (256 to 511 by default) drives the pin value from gpio_out and the output enable from gpio_en at the pin's index.
- R8: Output word bit 9 inverts the pin output value.
- R9: Output word bit 10 takes the pin output enable from gpio_en at the pin's index, whatever the code selects.
- R10: Output word bit 11 inverts the pin output enable after its source is chosen.
- R11: A bus write with bus_wr high stores a select word at the next rising edge. bus_rdata shows the addressed word in the same cycle, with bits above the word width reading 0. Unmapped addresses read 0, and writes to them change no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for select words |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS | Pin input levels |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |
| periph_in | output | NUM_IN_SIG | Signals delivered to peripheral inputs |
| direct_in | input | NUM_IN_SIG | Direct-path signals for peripheral inputs |
| periph_out | input | NUM_PSIG | Peripheral output values |
| periph_oe | input | NUM_PSIG | Peripheral output enables |
| gpio_out | input | NUM_PINS | Simple output register bits |
| gpio_en | input | NUM_PINS | Simple output-enable register bits |

## Verification
A select word can be rewritten in the same cycle that the pin feeding the current route changes level. The bench provokes this by driving a new input word for signal 3 and a new pin_in pattern on the same falling edge. Just after that edge, periph_in must follow the new pin level through the old select word. After the next rising edge, it must show the value of the newly written constant code. A wrong answer in either half shows a write taking effect too early or the routing being registered.

// File: rtl/ioxb_pkg.sv
package ioxb_pkg;
  localparam int unsigned IN_CODE_W   = 6;
  localparam int unsigned IN_WORD_W   = 8;
  localparam int unsigned IN_INV_BIT  = 6;
  localparam int unsigned IN_ROUTE_BIT = 7;
  localparam logic [IN_CODE_W-1:0] CODE_HIGH = 6'h20;
  localparam logic [IN_CODE_W-1:0] CODE_LOW  = 6'h30;
  localparam logic [IN_WORD_W-1:0] IN_RST_WORD = 8'h30;
endpackage

// File: rtl/ioxb_cfg_regs.sv
module ioxb_cfg_regs
  import ioxb_pkg::*;
#(
  parameter int unsigned NUM_IN_SIG = 16,
  parameter int unsigned NUM_PINS   = 25,
  parameter int unsigned OSEL_W     = 9,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned OUT_BASE   = 128,
  localparam int unsigned OW        = OSEL_W + 3,
  localparam int unsigned IN_IDX_W  = (NUM_IN_SIG > 1) ? $clog2(NUM_IN_SIG) : 1,
  localparam int unsigned PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                               clk,
  input  logic                               rst_ni,
  input  logic                               bus_wr,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [31:0]                        bus_wdata,
  output logic [31:0]                        bus_rdata,
  output logic                               rst_sync_n,
  output logic [NUM_IN_SIG-1:0][IN_WORD_W-1:0] in_cfg,
  output logic [NUM_PINS-1:0][OW-1:0]        out_cfg
);
  localparam logic [OW-1:0] OUT_RST_WORD = OW'(1) << (OSEL_W - 1);

  logic rst_meta_q;
  logic in_hit, out_hit, in_en, out_en;
  logic [ADDR_W-1:0]    out_off;
  logic [IN_IDX_W-1:0]  in_idx;
  logic [PIN_IDX_W-1:0] out_idx;
  logic [NUM_IN_SIG-1:0][IN_WORD_W-1:0] in_q, in_nxt;
  logic [NUM_PINS-1:0][OW-1:0]          out_q, out_nxt;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // address decode
  assign in_hit  = (32'(bus_addr) < 32'(NUM_IN_SIG));
  assign out_hit = (32'(bus_addr) >= 32'(OUT_BASE)) &&
                   (32'(bus_addr) <  32'(OUT_BASE + NUM_PINS));
  assign out_off = bus_addr - ADDR_W'(OUT_BASE);
  assign in_idx  = bus_addr[IN_IDX_W-1:0];
  assign out_idx = out_off[PIN_IDX_W-1:0];
  assign in_en   = bus_wr & in_hit;
  assign out_en  = bus_wr & out_hit;

  // next state
  always_comb begin
    in_nxt  = in_q;
    out_nxt = out_q;
    if (in_en)  in_nxt[in_idx]   = bus_wdata[IN_WORD_W-1:0];
    if (out_en) out_nxt[out_idx] = bus_wdata[OW-1:0];
  end

  // state registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      in_q <= {NUM_IN_SIG{IN_RST_WORD}};
    end else if (in_en) begin
      in_q <= in_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q <= {NUM_PINS{OUT_RST_WORD}};
    end else if (out_en) begin
      out_q <= out_nxt;
    end
  end

  // readback
  always_comb begin
    bus_rdata = '0;
    if (in_hit) begin
      bus_rdata[IN_WORD_W-1:0] = in_q[in_idx];
    end else if (out_hit) begin
      bus_rdata[OW-1:0] = out_q[out_idx];
    end
  end

  assign in_cfg  = in_q;
  assign out_cfg = out_q;
endmodule

// File: rtl/ioxb_in_route.sv
module ioxb_in_route
  import ioxb_pkg::*;
#(
  parameter int unsigned NUM_IN_SIG = 16,
  parameter int unsigned NUM_PINS   = 25,
  localparam int unsigned PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_IN_SIG-1:0][IN_WORD_W-1:0] in_cfg,
  input  logic [NUM_PINS-1:0]                  pin_in,
  input  logic [NUM_IN_SIG-1:0]                direct_in,
  output logic [NUM_IN_SIG-1:0]                periph_in
);
  for (genvar s = 0; s < NUM_IN_SIG; s++) begin : g_sig
    logic [IN_CODE_W-1:0] code;
    logic                 picked;

    assign code = in_cfg[s][IN_CODE_W-1:0];

    always_comb begin
      if (32'(code) < 32'(NUM_PINS)) begin
        picked = pin_in[code[PIN_IDX_W-1:0]];
      end else if (code == CODE_HIGH) begin
        picked = 1'b1;
      end else begin
        picked = 1'b0;
      end
    end

    assign periph_in[s] = in_cfg[s][IN_ROUTE_BIT] ? (picked ^ in_cfg[s][IN_INV_BIT])
                                                  : direct_in[s];
  end
endmodule

// File: rtl/ioxb_out_route.sv
module ioxb_out_route #(
  parameter int unsigned NUM_PINS  = 25,
  parameter int unsigned NUM_PSIG  = 256,
  parameter int unsigned OSEL_W    = 9,
  localparam int unsigned OW       = OSEL_W + 3,
  localparam int unsigned PIDX_W   = (NUM_PSIG > 1) ? $clog2(NUM_PSIG) : 1
) (
  input  logic [NUM_PINS-1:0][OW-1:0] out_cfg,
  input  logic [NUM_PSIG-1:0]         periph_out,
  input  logic [NUM_PSIG-1:0]         periph_oe,
  input  logic [NUM_PINS-1:0]         gpio_out,
  input  logic [NUM_PINS-1:0]         gpio_en,
  output logic [NUM_PINS-1:0]         pin_out,
  output logic [NUM_PINS-1:0]         pin_oe
);
  localparam int unsigned INV_BIT    = OSEL_W;
  localparam int unsigned OESRC_BIT  = OSEL_W + 1;
  localparam int unsigned OEINV_BIT  = OSEL_W + 2;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [OSEL_W-1:0] sel;
    logic              use_reg;
    logic              raw_val, raw_oe, oe_src;

    assign sel     = out_cfg[p][OSEL_W-1:0];
    assign use_reg = (32'(sel) >= 32'(NUM_PSIG));

    always_comb begin
      if (use_reg) begin
        raw_val = gpio_out[p];
        raw_oe  = gpio_en[p];
      end else begin
        raw_val = periph_out[sel[PIDX_W-1:0]];
        raw_oe  = periph_oe[sel[PIDX_W-1:0]];
      end
    end

    assign oe_src     = out_cfg[p][OESRC_BIT] ? gpio_en[p] : raw_oe;
    assign pin_out[p] = raw_val ^ out_cfg[p][INV_BIT];
    assign pin_oe[p]  = oe_src ^ out_cfg[p][OEINV_BIT];
  end
endmodule

// File: rtl/ioxb_matrix.sv
module ioxb_matrix
  import ioxb_pkg::*;
#(
  parameter int unsigned NUM_IN_SIG = 16,
  parameter int unsigned NUM_PINS   = 25,
  parameter int unsigned NUM_PSIG   = 256,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned OUT_BASE   = 128
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_IN_SIG-1:0] periph_in,
  input  logic [NUM_IN_SIG-1:0] direct_in,
  input  logic [NUM_PSIG-1:0]   periph_out,
  input  logic [NUM_PSIG-1:0]   periph_oe,
  input  logic [NUM_PINS-1:0]   gpio_out,
  input  logic [NUM_PINS-1:0]   gpio_en
);
  localparam int unsigned OSEL_W = $clog2(NUM_PSIG) + 1;
  localparam int unsigned OW     = OSEL_W + 3;

  logic                                 rst_sync_n;
  logic [NUM_IN_SIG-1:0][IN_WORD_W-1:0] in_cfg;
  logic [NUM_PINS-1:0][OW-1:0]          out_cfg;

  ioxb_cfg_regs #(
    .NUM_IN_SIG(NUM_IN_SIG), .NUM_PINS(NUM_PINS), .OSEL_W(OSEL_W),
    .ADDR_W(ADDR_W), .OUT_BASE(OUT_BASE)
  ) u_regs (
    .clk(clk), .rst_ni(rst_ni), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_sync_n(rst_sync_n),
    .in_cfg(in_cfg), .out_cfg(out_cfg)
  );

  ioxb_in_route #(.NUM_IN_SIG(NUM_IN_SIG), .NUM_PINS(NUM_PINS)) u_in (
    .in_cfg(in_cfg), .pin_in(pin_in), .direct_in(direct_in), .periph_in(periph_in)
  );

  ioxb_out_route #(.NUM_PINS(NUM_PINS), .NUM_PSIG(NUM_PSIG), .OSEL_W(OSEL_W)) u_out (
    .out_cfg(out_cfg), .periph_out(periph_out), .periph_oe(periph_oe),
    .gpio_out(gpio_out), .gpio_en(gpio_en), .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/ioxb_matrix_chk.sv
module ioxb_matrix_chk #(
  parameter int unsigned NUM_IN_SIG = 16,
  parameter int unsigned NUM_PINS   = 25,
  parameter int unsigned OW         = 12,
  parameter int unsigned ADDR_W     = 8
) (
  input logic                          clk,
  input logic                          rst_sync_n,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic [NUM_IN_SIG-1:0][7:0]    in_cfg,
  input logic [NUM_PINS-1:0][OW-1:0]   out_cfg,
  input logic [NUM_IN_SIG-1:0]         periph_in,
  input logic [NUM_IN_SIG-1:0]         direct_in,
  input logic [NUM_PINS-1:0]           pin_out,
  input logic [NUM_PINS-1:0]           pin_oe,
  input logic [NUM_PINS-1:0]           gpio_out,
  input logic [NUM_PINS-1:0]           gpio_en
);
  localparam int unsigned SEL_MSB = OW - 4;

  for (genvar s = 0; s < NUM_IN_SIG; s++) begin : g_in_chk
    AST_DIRECT_PATH: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !in_cfg[s][7] |-> (periph_in[s] == direct_in[s])); // R5
    AST_CONST_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_cfg[s][7] && in_cfg[s][5:0] == 6'h20) |-> (periph_in[s] == !in_cfg[s][6])); // R3
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_out_chk
    AST_OE_FORCED: assert property (@(posedge clk) disable iff (!rst_sync_n)
      out_cfg[p][OW-2] |-> (pin_oe[p] == (gpio_en[p] ^ out_cfg[p][OW-1]))); // R9
    AST_REG_VALUE: assert property (@(posedge clk) disable iff (!rst_sync_n)
      out_cfg[p][SEL_MSB] |-> (pin_out[p] == (gpio_out[p] ^ out_cfg[p][OW-3]))); // R7
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == '0) |=> (in_cfg[0] == $past(bus_wdata[7:0]))); // R11
endmodule

bind ioxb_matrix ioxb_matrix_chk #(
  .NUM_IN_SIG(NUM_IN_SIG), .NUM_PINS(NUM_PINS), .OW(OW), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .in_cfg(in_cfg), .out_cfg(out_cfg),
  .periph_in(periph_in), .direct_in(direct_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .gpio_out(gpio_out), .gpio_en(gpio_en)
);

// File: tb/tb_ioxb_matrix.sv
`timescale 1ns/100ps
module tb_ioxb_matrix;
  localparam int NIS = 16;
  localparam int NP  = 25;
  localparam int NPS = 256;
  localparam int AW  = 8;
  localparam int OB  = 128;

  logic clk = 1'b0;
  logic rst_ni;
  logic bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe, gpio_out, gpio_en;
  logic [NIS-1:0] periph_in, direct_in;
  logic [NPS-1:0] periph_out, periph_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ioxb_matrix dut (
    .clk(clk), .rst_ni(rst_ni), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .periph_in(periph_in),
    .direct_in(direct_in), .periph_out(periph_out), .periph_oe(periph_oe),
    .gpio_out(gpio_out), .gpio_en(gpio_en)
  );

  // entry: [63:56] input word, [55:31] pin_in, [30] direct_in, [29] expected, [28:25] requirement
  localparam logic [63:0] VEC [12] = '{
    {8'h85, 25'h0000020, 1'b0, 1'b1, 4'd2, 25'h0},  // R2 pin 5 high
    {8'h85, 25'h1FFFFDF, 1'b0, 1'b0, 4'd2, 25'h0},  // R2 pin 5 low, rest high
    {8'h98, 25'h1000000, 1'b0, 1'b1, 4'd2, 25'h0},  // R2 top pin
    {8'hA0, 25'h0000000, 1'b0, 1'b1, 4'd3, 25'h0},  // R3 constant high
    {8'hB0, 25'h1FFFFFF, 1'b1, 1'b0, 4'd3, 25'h0},  // R3 constant low
    {8'h99, 25'h1FFFFFF, 1'b1, 1'b0, 4'd3, 25'h0},  // R3 code 25 low
    {8'hBF, 25'h1FFFFFF, 1'b1, 1'b0, 4'd3, 25'h0},  // R3 code 63 low
    {8'hC5, 25'h0000020, 1'b0, 1'b0, 4'd4, 25'h0},  // R4 inverted pin
    {8'hE0, 25'h0000000, 1'b0, 1'b0, 4'd4, 25'h0},  // R4 inverted high
    {8'hF0, 25'h0000000, 1'b0, 1'b1, 4'd4, 25'h0},  // R4 inverted low
    {8'h45, 25'h0000000, 1'b1, 1'b1, 4'd5, 25'h0},  // R5 direct, inv ignored
    {8'h05, 25'h1FFFFFF, 1'b0, 1'b0, 4'd5, 25'h0}   // R5 direct low
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_ni = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; direct_in = 16'hA5A5; periph_out = '0; periph_oe = '0;
    gpio_out = 25'h0000005; gpio_en = 25'h0000001;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'd0, r);        check("R1 in word", r, 32'h30);
    rd(8'(OB + 2), r);  check("R1 out word", r, 32'h100);
    check("R1 periph_in direct", 32'(periph_in), 32'hA5A5);
    check("R1 pin_out", 32'(pin_out), 32'h0000005);
    check("R1 pin_oe", 32'(pin_oe), 32'h0000001);

    // input-side vector table on signal 3
    foreach (VEC[i]) begin
      wr(8'd3, {24'h0, VEC[i][63:56]});
      pin_in = VEC[i][55:31];
      direct_in[3] = VEC[i][30];
      #1;
      checks++;
      if (periph_in[3] !== VEC[i][29]) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual=%0b expected=%0b",
                 VEC[i][28:25], i, periph_in[3], VEC[i][29]);
      end
    end

    // output side, pin 2
    gpio_out = '0; gpio_en = '0;
    wr(8'(OB + 2), 32'h007);
    periph_out[7] = 1'b1; periph_oe[7] = 1'b1;
    #1 check("R6 value", 32'(pin_out[2]), 32'd1);
    check("R6 enable", 32'(pin_oe[2]), 32'd1);
    periph_out = ~(256'd1 << 7); periph_oe = ~(256'd1 << 7);
    #1 check("R6 value low", 32'(pin_out[2]), 32'd0);
    check("R6 enable low", 32'(pin_oe[2]), 32'd0);

    wr(8'(OB + 2), 32'h100);
    gpio_out[2] = 1'b1; gpio_en[2] = 1'b0;
    #1 check("R7 reg value", 32'(pin_out[2]), 32'd1);
    check("R7 reg enable", 32'(pin_oe[2]), 32'd0);
    wr(8'(OB + 2), 32'h1FF);
    gpio_out[2] = 1'b0; gpio_en[2] = 1'b1;
    #1 check("R7 code 511 value", 32'(pin_out[2]), 32'd0);
    check("R7 code 511 enable", 32'(pin_oe[2]), 32'd1);

    periph_out = '0; periph_oe = '0;
    periph_out[7] = 1'b1;
    wr(8'(OB + 2), 32'h207);
    #1 check("R8 inverted value", 32'(pin_out[2]), 32'd0);

    gpio_en[2] = 1'b1; periph_oe[7] = 1'b0;
    wr(8'(OB + 2), 32'h407);
    #1 check("R9 forced enable", 32'(pin_oe[2]), 32'd1);

    periph_oe[7] = 1'b1;
    wr(8'(OB + 2), 32'h807);
    #1 check("R10 inverted peripheral enable", 32'(pin_oe[2]), 32'd0);
    wr(8'(OB + 2), 32'hC07);
    #1 check("R10 inverted forced enable", 32'(pin_oe[2]), 32'd0);

    // R11 bus
    wr(8'd5, 32'hFFFF_FFFF);
    rd(8'd5, r); check("R11 in word width", r, 32'hFF);
    wr(8'(OB + 4), 32'hFFFF_FFFF);
    rd(8'(OB + 4), r); check("R11 out word width", r, 32'hFFF);
    wr(8'd100, 32'h1234_5678);
    rd(8'd100, r); check("R11 unmapped read", r, 32'h0);
    rd(8'd0, r); check("R11 unmapped write no effect", r, 32'h30);
    rd(8'd200, r); check("R11 past output words", r, 32'h0);

    // same-cycle: rewrite signal 3 while its pin toggles
    wr(8'd3, 32'h85);
    pin_in = 25'h0000020;
    #1 check("R2 before overlap", 32'(periph_in[3]), 32'd1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'd3; bus_wdata = 32'hA0;
    pin_in = 25'h0;
    #1 check("R11 old word still routes", 32'(periph_in[3]), 32'd0);
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check("R3 new word after edge", 32'(periph_in[3]), 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule